// File: doc/BRIEF.md
# Keyed Special-Command Decoder

This block sits behind a serial programming front end and sees every completed 32-bit word write as an address and data pair. Most writes go to word-aligned addresses and are forwarded to the storage array as they arrive. A small set of keyed sequences, built from writes to odd (non word-aligned) addresses, reaches special functions instead. These functions switch write protection on or off, choose the polarity of the downstream reset and output-enable pin, open a status window for reads, and start a whole-array erase.

A two-write key opens every command except erase: 0xAAAAAAAA to address 0x55555, then 0x55555555 to address 0x2AAAA. A third write to 0x55555 then selects the function. Protection is removed only by two keyed commands in a row. Erase has its own three-write sequence. Once a command has been accepted, the block is in a special mode and array writes stop. An exit command (the key, then 0x00000000 at 0x55555) returns it to normal operation.

Both flags live in registers that are cleared only by a cold reset. A warm reset clears the sequence state and the modes, and copies the stored polarity choice to the applied-polarity output. A polarity change therefore takes effect only at the next warm reset.

Top module: `keyed_cmd_decoder`

## Requirements
- R1: With no sequence in progress, no special mode, no protection and no erase pending, a write to an address whose two low bits are 0 raises arrayWrEn in the same cycle as wrValid.
- R2: The key followed by data 0x000000A0 at 0x55555 sets protectOn and specialMode from the next cycle on.
- R3: While protectOn or specialMode is 1, aligned writes are discarded (arrayWrEn stays 0).
- R4: protectOn is cleared only by the key plus 0x00000080 at 0x55555, followed at once by the key plus 0x00000020 at 0x55555. That command also sets specialMode. Any other write inside the chain abandons it and leaves protectOn at 1. A lone key plus 0x00000020 does nothing.
- R5: A write that does not match the next expected step ends the sequence and is itself discarded. So is an unknown command code, or an unaligned write from idle that starts no sequence. The next write is decoded from idle.
- R6: The key plus 0x000000FF at 0x55555 sets polInvStored to 0 (reset active low, output enable active high). The key plus 0x0000FFFF sets it to 1 (inverted). Both set specialMode. polInvApplied copies polInvStored only while rstN is low.
- R7: The key plus 0x000000F2 at 0x55555 enters status mode. A read at rdAddr 1 then gives rdHit 1 and rdData[31:24] = 0xFF when protected or 0x00 when not, rdData[23] = polInvStored, other bits 0. Any other rdAddr gives rdHit 0 and rdData 0.
- R8: The writes 0x00555555 at 0x2AAAA, then 0x00AAAAAA at 0x55555, then 0x00555555 at 0x000B0 raise eraseStrobe for exactly the cycle of the third write. eraseBusy is 1 from the next cycle until the edge at which eraseDone is sampled high.
- R9: While eraseBusy is 1, every write is ignored: nothing reaches the array and no sequence advances.
- R10: The key plus 0x00000000 at 0x55555 clears specialMode and status mode and leaves both flags unchanged.
- R11: A cold reset (coldRstN low) clears protectOn, polInvStored, polInvApplied, specialMode, status mode and eraseBusy. A warm reset (rstN low) clears the modes, the sequence and eraseBusy but keeps protectOn and polInvStored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Cold reset, active low, clears the stored flags |
| rstN | input | 1 | Warm reset, active low, loads the applied polarity |
| wrValid | input | 1 | A completed word write is presented this cycle |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 32 | Data word of the write |
| rdAddr | input | ADDR_W | Read address, checked against the status location |
| eraseDone | input | 1 | The array reports that the erase has finished |
| arrayWrEn | output | 1 | Forward this write to the array |
| eraseStrobe | output | 1 | One-cycle erase request |
| eraseBusy | output | 1 | An erase is pending |
| protectOn | output | 1 | Write protection is active |
| specialMode | output | 1 | A special function is open; awaiting exit |
| polInvStored | output | 1 | Programmed polarity choice (1 = inverted) |
| polInvApplied | output | 1 | Polarity in effect since the last warm reset |
| rdHit | output | 1 | The read hits the status word |
| rdData | output | 32 | Status word when rdHit, else 0 |

## Verification
The write vectors mix plain aligned writes, correct key sequences for each command, keys cut short by an aligned write, unknown command codes and stray odd-address writes. This separates true decoding from address-only or data-only matching. The disable chain is tried both complete and broken, and a lone second half is also applied, which shows that protection can only be removed by the two-step form. Status reads under both polarity settings, warm against cold reset, and erase with writes during the pending window show that the flags, the applied polarity and the busy gate each follow their own rule.

// File: rtl/keyed_cmd_pkg.sv
`timescale 1ns/1ps
package keyed_cmd_pkg;
  localparam int WORD_W  = 32;
  localparam int ALIGN_W = 2;

  // key and command constants (addresses widened by the user)
  localparam logic [31:0] KEY_ADDR_A = 32'h0005_5555;
  localparam logic [31:0] KEY_ADDR_B = 32'h0002_AAAA;
  localparam logic [31:0] ERASE_ADDR_C = 32'h0000_00B0;
  localparam logic [31:0] STATUS_ADDR = 32'h0000_0001;
  localparam logic [WORD_W-1:0] KEY_DATA_A = 32'hAAAA_AAAA;
  localparam logic [WORD_W-1:0] KEY_DATA_B = 32'h5555_5555;
  localparam logic [WORD_W-1:0] ERASE_DATA_A = 32'h0055_5555;
  localparam logic [WORD_W-1:0] ERASE_DATA_B = 32'h00AA_AAAA;
  localparam logic [WORD_W-1:0] CMD_PROT_ON = 32'h0000_00A0;
  localparam logic [WORD_W-1:0] CMD_UNPROT_A = 32'h0000_0080;
  localparam logic [WORD_W-1:0] CMD_UNPROT_B = 32'h0000_0020;
  localparam logic [WORD_W-1:0] CMD_POL_NORM = 32'h0000_00FF;
  localparam logic [WORD_W-1:0] CMD_POL_INV = 32'h0000_FFFF;
  localparam logic [WORD_W-1:0] CMD_STATUS = 32'h0000_00F2;
  localparam logic [WORD_W-1:0] CMD_EXIT = 32'h0000_0000;

  // status word layout
  localparam int PROT_LSB = 24;
  localparam int PROT_W   = WORD_W - PROT_LSB;
  localparam int POL_BIT  = 23;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_KEY1,
    SEQ_KEY2,
    SEQ_UNP1,
    SEQ_UNP1K,
    SEQ_UNP2,
    SEQ_ER1,
    SEQ_ER2
  } seq_state_t;

  typedef struct packed {
    logic plainWrite;
    logic setProt;
    logic clrProt;
    logic polNorm;
    logic polInv;
    logic enterSpecial;
    logic enterStatus;
    logic exitSpecial;
    logic startErase;
  } cmd_strobe_t;
endpackage

// File: rtl/keyed_cmd_ctrl.sv
`timescale 1ns/1ps
module keyed_cmd_ctrl
  import keyed_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstAllN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              busy,
  output cmd_strobe_t       strb
);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);
  localparam logic [ADDR_W-1:0] ADDR_C = ADDR_W'(ERASE_ADDR_C);

  seq_state_t state, stateNext;
  logic       accept;
  logic       aligned;
  logic       atA;

  assign accept  = wrValid && !busy && rstAllN;
  assign aligned = (wrAddr[ALIGN_W-1:0] == '0);
  assign atA     = (wrAddr == ADDR_A);

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN) state <= SEQ_IDLE;
    else          state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (accept) begin
      stateNext = SEQ_IDLE;
      unique case (state)
        SEQ_IDLE: begin
          if (atA && wrData == KEY_DATA_A)                     stateNext = SEQ_KEY1;
          else if (wrAddr == ADDR_B && wrData == ERASE_DATA_A) stateNext = SEQ_ER1;
          else                                                 strb.plainWrite = aligned;
        end
        SEQ_KEY1: begin
          if (wrAddr == ADDR_B && wrData == KEY_DATA_B) stateNext = SEQ_KEY2;
        end
        SEQ_KEY2: begin
          if (atA) begin
            if (wrData == CMD_PROT_ON) begin
              strb.setProt      = 1'b1;
              strb.enterSpecial = 1'b1;
            end else if (wrData == CMD_UNPROT_A) begin
              stateNext = SEQ_UNP1;
            end else if (wrData == CMD_POL_NORM) begin
              strb.polNorm      = 1'b1;
              strb.enterSpecial = 1'b1;
            end else if (wrData == CMD_POL_INV) begin
              strb.polInv       = 1'b1;
              strb.enterSpecial = 1'b1;
            end else if (wrData == CMD_STATUS) begin
              strb.enterStatus  = 1'b1;
              strb.enterSpecial = 1'b1;
            end else if (wrData == CMD_EXIT) begin
              strb.exitSpecial  = 1'b1;
            end
          end
        end
        SEQ_UNP1: begin
          if (atA && wrData == KEY_DATA_A) stateNext = SEQ_UNP1K;
        end
        SEQ_UNP1K: begin
          if (wrAddr == ADDR_B && wrData == KEY_DATA_B) stateNext = SEQ_UNP2;
        end
        SEQ_UNP2: begin
          if (atA && wrData == CMD_UNPROT_B) begin
            strb.clrProt      = 1'b1;
            strb.enterSpecial = 1'b1;
          end
        end
        SEQ_ER1: begin
          if (atA && wrData == ERASE_DATA_B) stateNext = SEQ_ER2;
        end
        SEQ_ER2: begin
          if (wrAddr == ADDR_C && wrData == ERASE_DATA_A) strb.startErase = 1'b1;
        end
        default: stateNext = SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keyed_cmd_datapath.sv
`timescale 1ns/1ps
module keyed_cmd_datapath
  import keyed_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              warmRstN,
  input  logic              rstAllN,
  input  cmd_strobe_t       strb,
  input  logic              eraseDone,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              arrayWrEn,
  output logic              eraseStrobe,
  output logic              eraseBusy,
  output logic              protectOn,
  output logic              specialMode,
  output logic              polInvStored,
  output logic              polInvApplied,
  output logic              rdHit,
  output logic [WORD_W-1:0] rdData
);
  logic statusMode;

  // flags survive a warm reset
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      protectOn    <= 1'b0;
      polInvStored <= 1'b0;
    end else begin
      if (strb.setProt)      protectOn <= 1'b1;
      else if (strb.clrProt) protectOn <= 1'b0;
      if (strb.polNorm)      polInvStored <= 1'b0;
      else if (strb.polInv)  polInvStored <= 1'b1;
    end
  end

  // applied polarity is sampled only while the warm reset is held
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)      polInvApplied <= 1'b0;
    else if (!warmRstN) polInvApplied <= polInvStored;
  end

  always_ff @(posedge clk or negedge rstAllN) begin
    if (!rstAllN) begin
      specialMode <= 1'b0;
      statusMode  <= 1'b0;
      eraseBusy   <= 1'b0;
    end else begin
      if (strb.exitSpecial)       specialMode <= 1'b0;
      else if (strb.enterSpecial) specialMode <= 1'b1;
      if (strb.exitSpecial)       statusMode <= 1'b0;
      else if (strb.enterStatus)  statusMode <= 1'b1;
      if (strb.startErase)        eraseBusy <= 1'b1;
      else if (eraseDone)         eraseBusy <= 1'b0;
    end
  end

  assign arrayWrEn   = strb.plainWrite && !protectOn && !specialMode && !eraseBusy;
  assign eraseStrobe = strb.startErase;
  assign rdHit       = statusMode && (rdAddr == ADDR_W'(STATUS_ADDR));

  always_comb begin
    rdData = '0;
    if (rdHit) begin
      rdData[PROT_LSB +: PROT_W] = {PROT_W{protectOn}};
      rdData[POL_BIT]            = polInvStored;
    end
  end
endmodule

// File: rtl/keyed_cmd_decoder.sv
`timescale 1ns/1ps
module keyed_cmd_decoder
  import keyed_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              eraseDone,
  output logic              arrayWrEn,
  output logic              eraseStrobe,
  output logic              eraseBusy,
  output logic              protectOn,
  output logic              specialMode,
  output logic              polInvStored,
  output logic              polInvApplied,
  output logic              rdHit,
  output logic [31:0]       rdData
);
  cmd_strobe_t strb;
  logic        rstAllN;

  assign rstAllN = rstN & coldRstN;

  keyed_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstAllN (rstAllN),
    .wrValid (wrValid),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .busy    (eraseBusy),
    .strb    (strb)
  );

  keyed_cmd_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk           (clk),
    .coldRstN      (coldRstN),
    .warmRstN      (rstN),
    .rstAllN       (rstAllN),
    .strb          (strb),
    .eraseDone     (eraseDone),
    .rdAddr        (rdAddr),
    .arrayWrEn     (arrayWrEn),
    .eraseStrobe   (eraseStrobe),
    .eraseBusy     (eraseBusy),
    .protectOn     (protectOn),
    .specialMode   (specialMode),
    .polInvStored  (polInvStored),
    .polInvApplied (polInvApplied),
    .rdHit         (rdHit),
    .rdData        (rdData)
  );
endmodule

// File: rtl/keyed_cmd_checker.sv
`timescale 1ns/1ps
module keyed_cmd_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              coldRstN,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              arrayWrEn,
  input logic              eraseStrobe,
  input logic              eraseBusy,
  input logic              protectOn,
  input logic              specialMode,
  input logic              polInvApplied,
  input logic              rdHit,
  input logic [31:0]       rdData
);
  assert_wr_aligned_R1: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    arrayWrEn |-> (wrValid && wrAddr[1:0] == 2'b00));

  assert_no_wr_locked_R3: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    (protectOn || specialMode) |-> !arrayWrEn);

  assert_applied_held_R6: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    rstN |=> $stable(polInvApplied));

  assert_status_clean_R7: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    rdHit |-> (rdData[22:0] == 23'd0));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    eraseStrobe |=> !eraseStrobe);

  assert_busy_follows_R8: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    eraseStrobe |=> eraseBusy);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rstN || !coldRstN)
    eraseBusy |-> (!arrayWrEn && !eraseStrobe));
endmodule

bind keyed_cmd_decoder keyed_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/keyed_cmd_decoder_tb.sv
`timescale 1ns/1ps
module keyed_cmd_decoder_tb;
  localparam int ADDR_W = 20;
  localparam int NVEC   = 46;

  logic              clk = 1'b0;
  logic              coldRstN = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0]       wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic              eraseDone = 1'b0;
  logic              arrayWrEn, eraseStrobe, eraseBusy, protectOn, specialMode;
  logic              polInvStored, polInvApplied, rdHit;
  logic [31:0]       rdData;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  logic seenWrEn, seenStrb;

  always #5 clk = ~clk;

  keyed_cmd_decoder #(.ADDR_W(ADDR_W)) u_dut (.*);

  // {addr, data, expWrEn, expProt, expSpecial, expPolStored}
  localparam logic [55:0] VEC [NVEC] = '{
    {20'h00100, 32'h12345678, 4'b1000},  // R1 plain write
    {20'h55555, 32'hAAAAAAAA, 4'b0000},
    {20'h2AAAA, 32'h55555555, 4'b0000},
    {20'h55555, 32'h000000A0, 4'b0110},  // R2 protect on
    {20'h00200, 32'hCAFE0001, 4'b0110},  // R3 discarded
    {20'h55555, 32'hAAAAAAAA, 4'b0110},
    {20'h2AAAA, 32'h55555555, 4'b0110},
    {20'h55555, 32'h00000000, 4'b0100},  // R10 exit keeps flag
    {20'h00300, 32'hCAFE0002, 4'b0100},  // R3 protected
    {20'h55555, 32'hAAAAAAAA, 4'b0100},
    {20'h2AAAA, 32'h55555555, 4'b0100},
    {20'h55555, 32'h00000080, 4'b0100},
    {20'h55555, 32'hAAAAAAAA, 4'b0100},
    {20'h2AAAA, 32'h55555555, 4'b0100},
    {20'h55555, 32'h00000020, 4'b0010},  // R4 unprotect
    {20'h55555, 32'hAAAAAAAA, 4'b0010},
    {20'h2AAAA, 32'h55555555, 4'b0010},
    {20'h55555, 32'h00000000, 4'b0000},  // R10
    {20'h00304, 32'hCAFE0003, 4'b1000},
    {20'h55555, 32'hAAAAAAAA, 4'b0000},
    {20'h00400, 32'hCAFE0004, 4'b0000},  // R5 abort discarded
    {20'h00404, 32'hCAFE0005, 4'b1000},
    {20'h55555, 32'hAAAAAAAA, 4'b0000},
    {20'h2AAAA, 32'h55555555, 4'b0000},
    {20'h55555, 32'h00000033, 4'b0000},  // R5 unknown code
    {20'h00408, 32'hCAFE0006, 4'b1000},
    {20'h00001, 32'hCAFE0007, 4'b0000},  // R5 stray odd address
    {20'h55555, 32'hAAAAAAAA, 4'b0000},
    {20'h2AAAA, 32'h55555555, 4'b0000},
    {20'h55555, 32'h000000A0, 4'b0110},
    {20'h55555, 32'hAAAAAAAA, 4'b0110},
    {20'h2AAAA, 32'h55555555, 4'b0110},
    {20'h55555, 32'h00000080, 4'b0110},
    {20'h00500, 32'hCAFE0008, 4'b0110},  // R4 chain broken
    {20'h55555, 32'hAAAAAAAA, 4'b0110},
    {20'h2AAAA, 32'h55555555, 4'b0110},
    {20'h55555, 32'h00000020, 4'b0110},  // R4 lone second half
    {20'h55555, 32'hAAAAAAAA, 4'b0110},
    {20'h2AAAA, 32'h55555555, 4'b0110},
    {20'h55555, 32'h00000000, 4'b0100},
    {20'h55555, 32'hAAAAAAAA, 4'b0100},
    {20'h2AAAA, 32'h55555555, 4'b0100},
    {20'h55555, 32'h0000FFFF, 4'b0111},  // R6 inverted polarity
    {20'h55555, 32'hAAAAAAAA, 4'b0111},
    {20'h2AAAA, 32'h55555555, 4'b0111},
    {20'h55555, 32'h000000F2, 4'b0111}   // R7 status mode
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = a;
    wrData  = d;
    #1;
    seenWrEn = arrayWrEn;
    seenStrb = eraseStrobe;
    @(posedge clk);
    #1;
    wrValid = 1'b0;
  endtask

  task automatic keyPrefix();
    wr(20'h55555, 32'hAAAAAAAA);
    wr(20'h2AAAA, 32'h55555555);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    coldRstN = 1'b1;
    rstN     = 1'b1;
    #1;
    check("R11 reset protectOn", 32'(protectOn), 0);
    check("R11 reset specialMode", 32'(specialMode), 0);
    check("R11 reset polarity", {30'd0, polInvStored, polInvApplied}, 0);
    check("R11 reset busy", 32'(eraseBusy), 0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][55:36], VEC[i][35:4]);
      check($sformatf("R1/R3 table step %0d wrEn", i), 32'(seenWrEn), 32'(VEC[i][3]));
      check($sformatf("R2/R4 table step %0d prot", i), 32'(protectOn), 32'(VEC[i][2]));
      check($sformatf("R10/R5 table step %0d special", i), 32'(specialMode), 32'(VEC[i][1]));
      check($sformatf("R6 table step %0d pol", i), 32'(polInvStored), 32'(VEC[i][0]));
    end

    // R7 status read: protected, inverted polarity
    rdAddr = 20'h00001;
    #1;
    check("R7 status hit", 32'(rdHit), 1);
    check("R7 status word prot+inv", rdData, 32'hFF800000);
    rdAddr = 20'h00002;
    #1;
    check("R7 other address hit", 32'(rdHit), 0);
    check("R7 other address data", rdData, 0);
    rdAddr = 20'h00001;
    keyPrefix();
    wr(20'h55555, 32'h000000FF);
    check("R6 normal polarity stored", 32'(polInvStored), 0);
    check("R7 status word prot+norm", rdData, 32'hFF000000);
    keyPrefix();
    wr(20'h55555, 32'h0000FFFF);
    check("R6 applied not yet changed", 32'(polInvApplied), 0);
    keyPrefix();
    wr(20'h55555, 32'h00000000);
    check("R10 exit closes status", 32'(rdHit), 0);
    check("R10 exit keeps protect", 32'(protectOn), 1);

    // R11 warm reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R6 applied after warm reset", 32'(polInvApplied), 1);
    check("R11 warm keeps protect", 32'(protectOn), 1);
    check("R11 warm keeps polarity", 32'(polInvStored), 1);
    wr(20'h00600, 32'h1);
    check("R3 still protected after warm reset", 32'(seenWrEn), 0);

    // R11 cold reset
    @(negedge clk); coldRstN = 1'b0;
    @(negedge clk); coldRstN = 1'b1;
    #1;
    check("R11 cold clears protect", 32'(protectOn), 0);
    check("R11 cold clears polarity", {30'd0, polInvStored, polInvApplied}, 0);

    // R8 wrong erase tail
    wr(20'h2AAAA, 32'h00555555);
    wr(20'h55555, 32'h00AAAAAA);
    wr(20'h000B4, 32'h00555555);
    check("R8 wrong tail no strobe", 32'(seenStrb), 0);
    check("R8 wrong tail no busy", 32'(eraseBusy), 0);

    // R8 real erase
    wr(20'h2AAAA, 32'h00555555);
    wr(20'h55555, 32'h00AAAAAA);
    wr(20'h000B0, 32'h00555555);
    check("R8 strobe on third write", 32'(seenStrb), 1);
    check("R8 third write not forwarded", 32'(seenWrEn), 0);
    check("R8 busy after strobe", 32'(eraseBusy), 1);
    check("R8 strobe single cycle", 32'(eraseStrobe), 0);
    wr(20'h00700, 32'h2);
    check("R9 write while busy", 32'(seenWrEn), 0);
    keyPrefix();
    wr(20'h55555, 32'h000000A0);
    check("R9 command while busy", 32'(protectOn), 0);
    check("R9 busy holds", 32'(eraseBusy), 1);
    @(negedge clk); eraseDone = 1'b1;
    @(posedge clk); #1; eraseDone = 1'b0;
    check("R8 busy clears on done", 32'(eraseBusy), 0);
    wr(20'h00704, 32'h3);
    check("R1 write after erase", 32'(seenWrEn), 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule